// File: doc/BRIEF.md
# Keyed watchdog timer with early-warning interrupt

This block is a memory-mapped watchdog timer for a system-on-chip. A free-running 10 ms tick enable, produced elsewhere, decrements a 15-bit down-counter. When the counter expires, the block emits a single-cycle reset request to the chip's reset logic. The block also records the cause in a status latch that survives the request, so that boot software can tell a watchdog reboot from a cold start. A software agent keeps the system alive by writing a 16-bit key to the feed register. Every other control action also needs its own key: re-enabling, clearing the timeout status, and a two-step disable handshake across two registers. The enable state and the timeout status are reported as 16-bit code words, not as single bits, so a stray write or a stuck bit cannot be mistaken for a valid state.

One tick before the counter expires, the block raises an early-warning event. This event drives an interrupt through a mask bit, and a force bit can also drive it directly. A debug input pauses the countdown while a debugger is attached, unless software has set an override bit. The register bus is a plain single-cycle 32-bit port with separate write and read strobes. Only the low 16 bits of data are meaningful. There is no streaming interface and no back-pressure: every access completes in the cycle it is presented, and read data appears on the following cycle.

Top module: `keyed_wdt`

## Requirements
- R1: After rst_n the block is disabled: reg 0x0C reads 0xDABE. The timeout register (0x04) and the count (0x14) both read 6000. Status (0x10), event (0x20), mask (0x24), force (0x28) and the override bit 0 of 0x18 read 0. The irq and reset_req outputs are low.
- R2: A write to 0x04 stores bits 14:0 of the data as the timeout. A read of 0x04 returns those 15 bits, with bits 31:15 zero.
- R3: Writing 0xFEED (low 16 bits) to 0x00 loads the count from the timeout register. A write of any other value to 0x00 leaves the count unchanged.
- R4: Writing 0xACED to 0x1C while disabled enables the block, and 0x0C then reads 0x0000. The count does not move on ticks until the next feed. After that feed it decreases by one per tick.
- R5: The block is disabled only by writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C. A 0xCAFE write without that preceding key has no effect. Another write to 0x08 between the two steps also cancels the sequence. While disabled, ticks do not change the count.
- R6: A counting tick that finds the count at 0 drives reset_req high for exactly the next cycle and reloads the count from the timeout register.
- R7: After an expiry, 0x10 reads 0xCFE8 until 0xE8B4 is written to it, after which it reads 0x0000. Writes of other values do not clear it, and neither does the reset request.
- R8: A counting tick that takes the count from 1 to 0 sets event bit 0 of 0x20, one tick before the reset request. Writing a 1 in bit 0 of 0x20 clears the event.
- R9: irq equals (event bit 0 AND mask bit 0 of 0x24) OR force bit 0 of 0x28.
- R10: Bit 15 of a 0x14 read is 1 when the read is issued in the same cycle as a counting tick. Bits 14:0 then hold the count from before that tick. Otherwise bit 15 is 0.
- R11: Bit 1 of 0x18 reflects debug_mode and cannot be written. Bit 0 is writable. While debug_mode is high and bit 0 is 0, ticks do not count; with bit 0 set they do.
- R12: Read data appears on bus_rdata the cycle after bus_rd and holds until the next read. Write-only and unmapped offsets (0x00, 0x08, 0x1C, others) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle 10 ms tick enable |
| debug_mode | input | 1 | High while a debugger is attached |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; bits 15:0 used |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Early-warning interrupt |
| reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
A write takes effect at the clock edge where its strobe is sampled. Read data, the reset request and the interrupt are each due one edge after the strobe or tick that causes them. The bench drives every strobe and tick for exactly one cycle starting at a falling edge, and samples at the next falling edge, one edge after the cause. It checks reset_req right after each tick and irq right after each operation, comparing both against a reference model in the bench that advances once per tick. The coincident read-and-tick case is driven in a single cycle, so the busy flag and the pre-tick count are due on the same read return.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 6;
  localparam int KEY_W  = 16;
  localparam int N_REG  = 11;
  localparam int BUSY_BIT = KEY_W - 1;

  // register index; byte offset is index*4
  localparam int IX_FEED  = 0;
  localparam int IX_TOUT  = 1;
  localparam int IX_DIS1  = 2;
  localparam int IX_DIS2  = 3;
  localparam int IX_STAT  = 4;
  localparam int IX_CNT   = 5;
  localparam int IX_DBG   = 6;
  localparam int IX_RSTRT = 7;
  localparam int IX_EVT   = 8;
  localparam int IX_MASK  = 9;
  localparam int IX_FORCE = 10;

  localparam logic [ADDR_W-1:0] OFS_TOUT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DIS2  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_DBG   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_FORCE = 6'h28;

  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hFEED;
  localparam logic [KEY_W-1:0] KEY_DIS1   = 16'h2BAD;
  localparam logic [KEY_W-1:0] KEY_DIS2   = 16'hCAFE;
  localparam logic [KEY_W-1:0] KEY_RSTRT  = 16'hACED;
  localparam logic [KEY_W-1:0] KEY_CLR    = 16'hE8B4;
  localparam logic [KEY_W-1:0] CODE_OFF   = 16'hDABE;
  localparam logic [KEY_W-1:0] CODE_ON    = 16'h0000;
  localparam logic [KEY_W-1:0] CODE_FIRED = 16'hCFE8;
  localparam logic [KEY_W-1:0] CODE_OK    = 16'h0000;

  typedef enum logic [1:0] {
    WS_OFF  = 2'd0,  // disabled
    WS_HOLD = 2'd1,  // enabled, waiting for a feed
    WS_RUN  = 2'd2   // counting
  } wdt_state_e;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [N_REG-1:0]  wsel,
  output logic [KEY_W-1:0]  wkey,
  input  logic [CNT_W-1:0]  timeout_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              count_busy,
  input  logic              disabled,
  input  logic              timed_out,
  input  logic              debug_mode,
  input  logic              jtag_en,
  input  logic              evt_q,
  input  logic              mask_q,
  input  logic              force_q,
  output logic [31:0]       bus_rdata
);
  logic        unused_hi;
  logic [31:0] rd_mux;

  assign unused_hi = ^bus_wdata[31:KEY_W];
  assign wkey      = bus_wdata[KEY_W-1:0];

  // one-hot write decode, offsets are index*4
  for (genvar g = 0; g < N_REG; g++) begin : g_dec
    assign wsel[g] = bus_wr && (bus_addr == ADDR_W'(g * 4));
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_TOUT:  rd_mux = 32'(timeout_q);
      OFS_DIS2:  rd_mux = 32'(disabled ? CODE_OFF : CODE_ON);
      OFS_STAT:  rd_mux = 32'(timed_out ? CODE_FIRED : CODE_OK);
      OFS_CNT: begin
        rd_mux = 32'(count_q);
        rd_mux[BUSY_BIT] = count_busy;
      end
      OFS_DBG:   rd_mux = {30'd0, debug_mode, jtag_en};
      OFS_EVT:   rd_mux = {31'd0, evt_q};
      OFS_MASK:  rd_mux = {31'd0, mask_q};
      OFS_FORCE: rd_mux = {31'd0, force_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REG-1:0] wsel,
  input  logic [KEY_W-1:0] wkey,
  input  logic             expire,
  input  logic             debug_mode,
  output logic             feed_go,
  output logic             count_en,
  output logic             disabled,
  output logic             timed_out,
  output logic             jtag_en
);
  wdt_state_e state_q, state_d;
  logic       dis_armed_q;
  logic       dis_go, restart_go, clr_go;

  assign feed_go    = wsel[IX_FEED]  && (wkey == KEY_FEED);
  assign restart_go = wsel[IX_RSTRT] && (wkey == KEY_RSTRT);
  assign clr_go     = wsel[IX_STAT]  && (wkey == KEY_CLR);
  assign dis_go     = wsel[IX_DIS2]  && (wkey == KEY_DIS2) && dis_armed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_OFF:  if (restart_go) state_d = WS_HOLD;
      WS_HOLD: if (dis_go) state_d = WS_OFF; else if (feed_go) state_d = WS_RUN;
      WS_RUN:  if (dis_go) state_d = WS_OFF;
      default: state_d = WS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WS_OFF;
      dis_armed_q <= 1'b0;
      timed_out   <= 1'b0;
      jtag_en     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wsel[IX_DIS1])      dis_armed_q <= (wkey == KEY_DIS1);
      else if (wsel[IX_DIS2]) dis_armed_q <= 1'b0;
      if (expire)      timed_out <= 1'b1;
      else if (clr_go) timed_out <= 1'b0;
      if (wsel[IX_DBG]) jtag_en <= wkey[0];
    end
  end

  assign disabled = (state_q == WS_OFF);
  assign count_en = (state_q == WS_RUN) && (!debug_mode || jtag_en);

  p_disable_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != WS_OFF && state_q == WS_OFF) |-> $past(wsel[IX_DIS2] && wkey == KEY_DIS2));
  p_no_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == WS_OFF) |-> (state_q != WS_RUN));
  p_status_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> $past(expire));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W       = 15,
  parameter int TIMEOUT_RST = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             to_wr,
  input  logic [CNT_W-1:0] to_data,
  input  logic             reload,
  input  logic             step,
  output logic [CNT_W-1:0] timeout_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire,
  output logic             bark,
  output logic             reset_req
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(TIMEOUT_RST);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  assign expire = step && !reload && (count_q == '0);
  assign bark   = step && !reload && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= RST_VAL;
      count_q   <= RST_VAL;
      reset_req <= 1'b0;
    end else begin
      if (to_wr) timeout_q <= to_data;
      if (reload || expire) count_q <= timeout_q;
      else if (step)        count_q <= count_q - ONE;
      reset_req <= expire;
    end
  end

  p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && count_q != '0) |=> (count_q == $past(count_q) - ONE));
  p_req_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(step));
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic bark,
  input  logic evt_wr,
  input  logic mask_wr,
  input  logic force_wr,
  input  logic wbit,
  output logic evt_q,
  output logic mask_q,
  output logic force_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      mask_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (bark)                evt_q <= 1'b1;
      else if (evt_wr && wbit) evt_q <= 1'b0;
      if (mask_wr)  mask_q  <= wbit;
      if (force_wr) force_q <= wbit;
    end
  end

  assign irq = (evt_q && mask_q) || force_q;

  p_evt_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(bark));
  p_evt_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_q) |-> $past(evt_wr && wbit));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int TIMEOUT_RST = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              debug_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              reset_req
);
  logic [N_REG-1:0] wsel;
  logic [KEY_W-1:0] wkey;
  logic [CNT_W-1:0] timeout_q, count_q;
  logic feed_go, count_en, step, expire, bark;
  logic disabled, timed_out, jtag_en;
  logic evt_q, mask_q, force_q;

  assign step = tick_en && count_en;

  wdt_regif #(.CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .wsel(wsel), .wkey(wkey), .timeout_q(timeout_q),
    .count_q(count_q), .count_busy(step), .disabled(disabled), .timed_out(timed_out),
    .debug_mode(debug_mode), .jtag_en(jtag_en), .evt_q(evt_q), .mask_q(mask_q),
    .force_q(force_q), .bus_rdata(bus_rdata)
  );

  wdt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .wkey(wkey), .expire(expire),
    .debug_mode(debug_mode), .feed_go(feed_go), .count_en(count_en),
    .disabled(disabled), .timed_out(timed_out), .jtag_en(jtag_en)
  );

  wdt_counter #(.CNT_W(CNT_W), .TIMEOUT_RST(TIMEOUT_RST)) u_counter (
    .clk(clk), .rst_n(rst_n), .to_wr(wsel[IX_TOUT]), .to_data(wkey[CNT_W-1:0]),
    .reload(feed_go), .step(step), .timeout_q(timeout_q), .count_q(count_q),
    .expire(expire), .bark(bark), .reset_req(reset_req)
  );

  wdt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .bark(bark), .evt_wr(wsel[IX_EVT]),
    .mask_wr(wsel[IX_MASK]), .force_wr(wsel[IX_FORCE]), .wbit(wkey[0]),
    .evt_q(evt_q), .mask_q(mask_q), .force_q(force_q), .irq(irq)
  );
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic clk = 0, rst_n = 0, tick_en = 0, debug_mode = 0, bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq, reset_req;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .debug_mode(debug_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .reset_req(reset_req)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int unsigned m_to = 6000, m_cnt = 6000;
  bit m_en = 0, m_run = 0, m_evt = 0, m_stat = 0, m_mask = 0, m_force = 0, m_jen = 0;

  function automatic logic [31:0] stat_code(input bit s);
    return s ? 32'h0000CFE8 : 32'h0;
  endfunction
  function automatic logic exp_irq();
    return (m_evt && m_mask) || m_force;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic model_tick(output bit rr);
    bit step;
    step = m_run && !(debug_mode && !m_jen);
    rr = 0;
    if (step) begin
      if (m_cnt == 0) begin m_cnt = m_to; m_stat = 1; rr = 1; end
      else begin if (m_cnt == 1) m_evt = 1; m_cnt--; end
    end
  endtask

  task automatic tick(input string req);
    bit rr;
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
    model_tick(rr);
    check(req, {31'd0, reset_req}, {31'd0, rr});
  endtask

  task automatic feed();
    wr(6'h00, 32'h0000FEED);
    m_cnt = m_to;
    if (m_en) m_run = 1;
  endtask

  task automatic set_to(input int unsigned v);
    wr(6'h04, v);
    m_to = v & 32'h7FFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 reset_req", {31'd0, reset_req}, 0);
    rdchk("R1 disabled code", 6'h0C, 32'h0000DABE);
    rdchk("R1 timeout", 6'h04, 32'd6000);
    rdchk("R1 count", 6'h14, 32'd6000);
    rdchk("R1 status", 6'h10, 0);
    rdchk("R1 event", 6'h20, 0);
    rdchk("R1 mask", 6'h24, 0);
    rdchk("R1 force", 6'h28, 0);
    rdchk("R1 override", 6'h18, 0);
    // R12 write-only / unmapped
    rdchk("R12 feed reads 0", 6'h00, 0);
    rdchk("R12 unmapped reads 0", 6'h3C, 0);
    // R2 timeout width
    set_to(32'hFFFF8005);
    rdchk("R2 masked timeout", 6'h04, 32'h5);
    set_to(10);
    rdchk("R2 timeout", 6'h04, 32'd10);
    // R4 restart then feed
    wr(6'h1C, 32'h0000ACED); m_en = 1;
    rdchk("R4 enabled code", 6'h0C, 0);
    tick("R4 no reset"); tick("R4 no reset"); tick("R4 no reset");
    rdchk("R4 held until feed", 6'h14, 32'd6000);
    feed();
    rdchk("R3 feed reload", 6'h14, 32'd10);
    tick("R4 counting");
    rdchk("R4 decrement", 6'h14, 32'd9);
    wr(6'h00, 32'h0000FEEE);
    rdchk("R3 wrong key ignored", 6'h14, 32'd9);
    // R10 read coinciding with tick
    @(negedge clk); bus_addr = 6'h14; bus_rd = 1; tick_en = 1;
    @(negedge clk); bus_rd = 0; tick_en = 0;
    check("R10 busy read", bus_rdata, 32'h00008009);
    m_cnt = 8;
    rdchk("R10 stable read", 6'h14, 32'd8);
    // R11 debug suspend
    debug_mode = 1;
    rdchk("R11 debug flag", 6'h18, 32'h2);
    tick("R11 frozen");
    rdchk("R11 frozen count", 6'h14, 32'd8);
    wr(6'h18, 32'h3); m_jen = 1;
    rdchk("R11 override set", 6'h18, 32'h3);
    tick("R11 override");
    rdchk("R11 counts with override", 6'h14, 32'd7);
    debug_mode = 0; wr(6'h18, 0); m_jen = 0;
    // R8/R6/R9 expiry path
    wr(6'h24, 1); m_mask = 1;
    for (int i = 0; i < 6; i++) tick("R6 pre-expiry");
    check("R8 no early irq", {31'd0, irq}, 0);
    tick("R8 bark tick");
    check("R8 bark irq", {31'd0, irq}, 1);
    rdchk("R8 event set", 6'h20, 1);
    rdchk("R7 not yet fired", 6'h10, 0);
    tick("R6 expiry pulse");
    @(negedge clk);
    check("R6 one cycle", {31'd0, reset_req}, 0);
    rdchk("R6 reload", 6'h14, 32'd10);
    rdchk("R7 fired code", 6'h10, 32'h0000CFE8);
    wr(6'h10, 32'h1234);
    rdchk("R7 wrong key keeps", 6'h10, 32'h0000CFE8);
    wr(6'h10, 32'h0000E8B4); m_stat = 0;
    rdchk("R7 cleared", 6'h10, 0);
    wr(6'h20, 1); m_evt = 0;
    rdchk("R8 ack", 6'h20, 0);
    check("R9 irq off after ack", {31'd0, irq}, 0);
    wr(6'h24, 0); m_mask = 0;
    wr(6'h28, 1); m_force = 1;
    check("R9 forced irq", {31'd0, irq}, 1);
    wr(6'h28, 0); m_force = 0;
    check("R9 unforced", {31'd0, irq}, 0);
    // R5 disable handshake
    wr(6'h0C, 32'h0000CAFE);
    rdchk("R5 lone second key", 6'h0C, 0);
    wr(6'h08, 32'h00002BAD); wr(6'h08, 32'h1111); wr(6'h0C, 32'h0000CAFE);
    rdchk("R5 broken sequence", 6'h0C, 0);
    wr(6'h08, 32'h00002BAD); wr(6'h0C, 32'h0000CAFE); wr(6'h0C, 32'h0000CAFE);
    m_en = 0; m_run = 0;
    rdchk("R5 disabled", 6'h0C, 32'h0000DABE);
    tick("R5 no count");
    rdchk("R5 count frozen", 6'h14, 32'(m_cnt));
    // random phase
    wr(6'h1C, 32'h0000ACED); m_en = 1;
    set_to(5);
    feed();
    for (int it = 0; it < 500; it++) begin
      int unsigned r;
      r = $urandom % 12;
      case (r)
        0: feed();
        1: set_to($urandom % 9);
        2: rdchk("R3 random count", 6'h14, 32'(m_cnt));
        3: begin wr(6'h20, 1); m_evt = 0; end
        4: begin wr(6'h10, 32'h0000E8B4); m_stat = 0; end
        5: rdchk("R7 random status", 6'h10, stat_code(m_stat));
        6: begin m_mask = $urandom % 2; wr(6'h24, 32'(m_mask)); end
        7: rdchk("R8 random event", 6'h20, {31'd0, m_evt});
        default: tick("R6 random tick");
      endcase
      check("R9 random irq", {31'd0, irq}, {31'd0, exp_irq()});
    end
    rd(6'h04, d);
    check("R2 final timeout", d, 32'(m_to));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule